// File: doc/BRIEF.md
# Descriptor Chain Walker for a Scatter-Gather DMA

This block walks a linked list of transfer descriptors held in memory and turns each one into a segment command for a separate data-moving engine. Software loads the address of the first descriptor, enables descriptor mode and pulses a submit strobe. The walker then reads the 48-byte descriptor as a single burst on its own read-only memory bus. It unpacks the fields and offers the segment downstream with a valid/ready handshake. Once the engine signals that the segment is done, the walker fetches the next descriptor or stops.

Each descriptor carries two control flags. One flag ends the chain and the other asks for an interrupt when its segment finishes. The interrupt is a single-cycle pulse, and the descriptor's id is presented with it. A read error during a fetch stops the chain and sets a sticky error flag. A soft reset lets any outstanding read burst complete before the walker goes idle. While descriptor mode is on, the legacy auto-repeat mode is forced off.

Top module: `sgdma_desc_walker`

## Requirements
- R1: A submit accepted in idle raises `m_araddr`-qualified `m_arvalid` on the next cycle with the first-descriptor address, burst length field 5 (six beats), size field 3 (8-byte beats) and burst type 1 (incrementing); `m_arvalid` and `m_araddr` stay unchanged until `m_arready`.
- R2: `cfg_submit` is ignored when `cfg_desc_en` is low or while the walker is busy: no read is issued and no segment results.
- R3: Beat k of the burst holds descriptor bytes 8k..8k+7, little-endian. Beat 0 holds flags [31:0] and id [63:32]. Beat 1 is the destination and beat 2 the source. Beat 3 is the next-descriptor address. Beat 4 holds y_len [31:0] and x_len [63:32], where x_len is the byte count minus one. Beat 5 holds the source stride [31:0] and the destination stride [63:32]. The segment outputs carry these values unchanged.
- R4: Once `seg_valid` is raised, it and the segment fields hold steady until `seg_ready` is seen, unless a soft reset intervenes.
- R5: After `seg_done`, if flags bit 0 is clear the walker fetches the descriptor at the next-descriptor address; if bit 0 is set it returns to idle and issues no further read.
- R6: If flags bit 1 is set, `irq_pulse` is high for exactly one cycle, the cycle after `seg_done` is sampled, with `irq_id` equal to the descriptor id. No pulse occurs when bit 1 is clear.
- R7: A read response with bit 1 set (slave or decode error) on any beat causes the following: no segment is offered, `err_sticky` is set, and the walker is idle after the last beat. `err_sticky` clears when the next submit is accepted.
- R8: A `soft_rst` pulse during a fetch keeps `m_rready` and `busy` high until the beat with `m_rlast` completes. The walker then goes idle without offering a segment.
- R9: `cyclic_active` follows `cfg_cyclic` only while `cfg_desc_en` is low, and is low whenever `cfg_desc_en` is high.
- R10: At most one read is outstanding: `m_arvalid` and `m_rready` are never high together.
- R11: After `rst_n` is asserted, `busy`, `m_arvalid`, `m_rready`, `seg_valid`, `irq_pulse` and `err_sticky` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_desc_en | input | 1 | Descriptor mode enable |
| cfg_cyclic | input | 1 | Legacy auto-repeat request |
| cfg_first_addr | input | ADDR_W | Address of the first descriptor |
| cfg_submit | input | 1 | Submit strobe |
| soft_rst | input | 1 | Soft reset, drains outstanding read |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 64 | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of burst |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_src | output | 64 | Source address |
| seg_dst | output | 64 | Destination address |
| seg_xlen | output | 32 | Bytes per row minus one |
| seg_ylen | output | 32 | Row count field |
| seg_src_stride | output | 32 | Source stride |
| seg_dst_stride | output | 32 | Destination stride |
| seg_id | output | 32 | Descriptor id |
| seg_done | input | 1 | Engine finished the segment |
| irq_pulse | output | 1 | End-of-segment interrupt pulse |
| irq_id | output | 32 | Id of the finished descriptor |
| err_sticky | output | 1 | Fetch error flag |
| busy | output | 1 | Walker not idle |
| cyclic_active | output | 1 | Effective auto-repeat mode |

## Verification
On every cycle, the assertions check the following properties. The segment and read address stay stable until accepted. Interrupts are single pulses that follow a done strobe. The read address and read data phases never overlap. A read burst is not abandoned partway. An error only appears together with an idle walker. The auto-repeat output is masked in descriptor mode. Only the bench scenarios can show the rest: that the unpacked fields land in the right outputs, that a chain follows its next pointers in order and stops on the last flag, that ignored submits issue no read, and that an errored or soft-reset fetch never produces a segment.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
    localparam int WORD_W     = 64;
    localparam int DESC_BYTES = 48;
    localparam int DESC_BEATS = DESC_BYTES * 8 / WORD_W;
    localparam int FLAG_LAST  = 0;
    localparam int FLAG_IRQ   = 1;

    typedef struct packed {
        logic [31:0] flags;
        logic [31:0] id;
        logic [63:0] dst;
        logic [63:0] src;
        logic [63:0] nxt;
        logic [31:0] ylen;
        logic [31:0] xlen;
        logic [31:0] sstride;
        logic [31:0] dstride;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FETCH,
        ST_OFFER,
        ST_WAIT
    } walk_st_e;
endpackage

// File: rtl/sgdma_ar_chan.sv
module sgdma_ar_chan
    import sgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int BEATS  = DESC_BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              arready,
    output logic              arvalid,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst
);
    localparam int SIZE_CODE = $clog2(WORD_W / 8);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } ar_t;

    ar_t ar_q, ar_d;

    always_comb begin
        ar_d = ar_q;
        if (issue) begin
            ar_d.valid = 1'b1;
            ar_d.addr  = issue_addr;
        end else if (ar_q.valid && arready) begin
            ar_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ar_q <= '0;
        else        ar_q <= ar_d;
    end

    assign arvalid = ar_q.valid;
    assign araddr  = ar_q.addr;
    assign arlen   = 8'(BEATS - 1);
    assign arsize  = 3'(SIZE_CODE);
    assign arburst = 2'b01;
endmodule

// File: rtl/sgdma_desc_collect.sv
module sgdma_desc_collect
    import sgdma_pkg::*;
#(
    parameter int BEATS = DESC_BEATS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        beat_ok,
    input  logic [63:0] beat_data,
    input  logic [1:0]  beat_resp,
    output desc_t       desc,
    output logic        bad
);
    localparam int IDX_W = $clog2(BEATS);

    typedef struct packed {
        logic [BEATS-1:0][63:0] words;
        logic [IDX_W-1:0]       idx;
        logic                   bad;
    } col_t;

    col_t col_q, col_d;
    logic unused_resp;
    assign unused_resp = beat_resp[0];

    always_comb begin
        col_d = col_q;
        if (clear) begin
            col_d.idx = '0;
            col_d.bad = 1'b0;
        end else if (beat_ok) begin
            for (int w = 0; w < BEATS; w++) begin
                if (col_q.idx == IDX_W'(w)) col_d.words[w] = beat_data;
            end
            if (col_q.idx != IDX_W'(BEATS - 1)) col_d.idx = col_q.idx + 1'b1;
            if (beat_resp[1]) col_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign bad = col_q.bad | (beat_ok & beat_resp[1]);

    always_comb begin
        desc.flags   = col_q.words[0][31:0];
        desc.id      = col_q.words[0][63:32];
        desc.dst     = col_q.words[1];
        desc.src     = col_q.words[2];
        desc.nxt     = col_q.words[3];
        desc.ylen    = col_q.words[4][31:0];
        desc.xlen    = col_q.words[4][63:32];
        desc.sstride = col_q.words[5][31:0];
        desc.dstride = col_q.words[5][63:32];
    end
endmodule

// File: rtl/sgdma_desc_walker.sv
module sgdma_desc_walker
    import sgdma_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_desc_en,
    input  logic              cfg_cyclic,
    input  logic [ADDR_W-1:0] cfg_first_addr,
    input  logic              cfg_submit,
    input  logic              soft_rst,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [63:0]       m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [63:0]       seg_src,
    output logic [63:0]       seg_dst,
    output logic [31:0]       seg_xlen,
    output logic [31:0]       seg_ylen,
    output logic [31:0]       seg_src_stride,
    output logic [31:0]       seg_dst_stride,
    output logic [31:0]       seg_id,
    input  logic              seg_done,
    output logic              irq_pulse,
    output logic [31:0]       irq_id,
    output logic              err_sticky,
    output logic              busy,
    output logic              cyclic_active
);
    typedef struct packed {
        walk_st_e    st;
        logic        flush;
        logic        err;
        logic        irq;
        logic [31:0] irq_id;
    } walk_t;

    walk_t             wk_q, wk_d;
    desc_t             desc;
    logic              col_bad;
    logic              beat_ok;
    logic              ar_issue;
    logic [ADDR_W-1:0] ar_addr;
    logic              unused_flags;

    assign unused_flags = ^{desc.flags[31:2], desc.nxt};
    assign beat_ok      = m_rvalid && m_rready;

    sgdma_ar_chan #(.ADDR_W(ADDR_W), .BEATS(DESC_BEATS)) u_ar (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (ar_issue),
        .issue_addr(ar_addr),
        .arready   (m_arready),
        .arvalid   (m_arvalid),
        .araddr    (m_araddr),
        .arlen     (m_arlen),
        .arsize    (m_arsize),
        .arburst   (m_arburst)
    );

    sgdma_desc_collect #(.BEATS(DESC_BEATS)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ar_issue),
        .beat_ok  (beat_ok),
        .beat_data(m_rdata),
        .beat_resp(m_rresp),
        .desc     (desc),
        .bad      (col_bad)
    );

    always_comb begin
        wk_d     = wk_q;
        wk_d.irq = 1'b0;
        ar_issue = 1'b0;
        ar_addr  = cfg_first_addr;
        unique case (wk_q.st)
            ST_IDLE: begin
                if (cfg_submit && cfg_desc_en && !soft_rst) begin
                    ar_issue   = 1'b1;
                    wk_d.err   = 1'b0;
                    wk_d.flush = 1'b0;
                    wk_d.st    = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (soft_rst) wk_d.flush = 1'b1;
                if (m_arvalid && m_arready) wk_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (soft_rst) wk_d.flush = 1'b1;
                if (beat_ok && m_rlast) begin
                    if (wk_d.flush) begin
                        wk_d.flush = 1'b0;
                        wk_d.st    = ST_IDLE;
                    end else if (col_bad) begin
                        wk_d.err = 1'b1;
                        wk_d.st  = ST_IDLE;
                    end else begin
                        wk_d.st = ST_OFFER;
                    end
                end
            end
            ST_OFFER: begin
                if (soft_rst)       wk_d.st = ST_IDLE;
                else if (seg_ready) wk_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (soft_rst) begin
                    wk_d.st = ST_IDLE;
                end else if (seg_done) begin
                    if (desc.flags[FLAG_IRQ]) begin
                        wk_d.irq    = 1'b1;
                        wk_d.irq_id = desc.id;
                    end
                    if (desc.flags[FLAG_LAST]) begin
                        wk_d.st = ST_IDLE;
                    end else begin
                        ar_issue = 1'b1;
                        ar_addr  = desc.nxt[ADDR_W-1:0];
                        wk_d.st  = ST_ADDR;
                    end
                end
            end
            default: wk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign m_rready       = (wk_q.st == ST_FETCH);
    assign seg_valid      = (wk_q.st == ST_OFFER);
    assign busy           = (wk_q.st != ST_IDLE);
    assign seg_src        = desc.src;
    assign seg_dst        = desc.dst;
    assign seg_xlen       = desc.xlen;
    assign seg_ylen       = desc.ylen;
    assign seg_src_stride = desc.sstride;
    assign seg_dst_stride = desc.dstride;
    assign seg_id         = desc.id;
    assign irq_pulse      = wk_q.irq;
    assign irq_id         = wk_q.irq_id;
    assign err_sticky     = wk_q.err;
    assign cyclic_active  = cfg_cyclic && !cfg_desc_en;
endmodule

// File: rtl/sgdma_walker_chk.sv
module sgdma_walker_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_desc_en,
    input logic              cyclic_active,
    input logic              soft_rst,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [63:0]       seg_src,
    input logic [31:0]       seg_id,
    input logic              seg_done,
    input logic              irq_pulse,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              m_rready,
    input logic              m_rvalid,
    input logic              m_rlast,
    input logic              err_sticky,
    input logic              busy
);
    assert_ar_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready && !soft_rst) |=> (seg_valid && $stable(seg_src) && $stable(seg_id)));

    assert_irq_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(seg_done));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> !busy);

    assert_burst_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rready && !(m_rvalid && m_rlast)) |=> (m_rready && busy));

    assert_cyclic_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_desc_en |-> !cyclic_active);

    assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_arvalid && m_rready));
endmodule

bind sgdma_desc_walker sgdma_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sgdma_desc_walker.sv
`timescale 1ns/1ps
module sim_sgdma_desc_walker;
    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_desc_en, cfg_cyclic, cfg_submit, soft_rst;
    logic [63:0] cfg_first_addr;
    logic        m_arvalid, m_arready, m_rvalid, m_rready, m_rlast;
    logic [63:0] m_araddr, m_rdata;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst, m_rresp;
    logic        seg_valid, seg_ready, seg_done;
    logic [63:0] seg_src, seg_dst;
    logic [31:0] seg_xlen, seg_ylen, seg_src_stride, seg_dst_stride, seg_id;
    logic        irq_pulse, err_sticky, busy, cyclic_active;
    logic [31:0] irq_id;

    sgdma_desc_walker u0 (.*);

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [31:0] xlen;
        logic [31:0] ylen;
        logic [31:0] ss;
        logic [31:0] ds;
        logic [31:0] id;
    } seg_s;

    int          n_chk = 0;
    int          n_fail = 0;
    seg_s        exp_seg[$];
    logic [31:0] exp_irq[$];
    logic [63:0] exp_ar[$];
    logic [63:0] mem [logic [63:0]];
    logic [63:0] err_addr = '1;
    int          r_gap = 0;
    int          rdy_dly = 0;
    int          beats_seen = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [63:0] a, input logic [31:0] flags, input logic [31:0] id,
                            input logic [63:0] dst, input logic [63:0] src, input logic [63:0] nxt,
                            input logic [31:0] ylen, input logic [31:0] xlen,
                            input logic [31:0] ss, input logic [31:0] ds, input bit expect_seg);
        seg_s s;
        mem[a]      = {id, flags};
        mem[a + 8]  = dst;
        mem[a + 16] = src;
        mem[a + 24] = nxt;
        mem[a + 32] = {xlen, ylen};
        mem[a + 40] = {ds, ss};
        exp_ar.push_back(a);
        if (expect_seg) begin
            s.src = src; s.dst = dst; s.xlen = xlen; s.ylen = ylen;
            s.ss = ss; s.ds = ds; s.id = id;
            exp_seg.push_back(s);
            if (flags[1]) exp_irq.push_back(id);
        end
    endtask

    task automatic submit(input logic [63:0] a);
        @(negedge clk);
        cfg_first_addr = a;
        cfg_submit = 1'b1;
        @(negedge clk);
        cfg_submit = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // Read responder: accepts the address, checks it, returns six beats
    initial begin
        logic [63:0] a, e;
        m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = '0; m_rlast = 1'b0;
        forever begin
            @(negedge clk);
            if (m_arvalid) begin
                a = m_araddr;
                check(m_arlen == 8'd5 && m_arsize == 3'd3 && m_arburst == 2'b01, "R1 burst shape",
                      {m_arlen, m_arsize, m_arburst}, {8'd5, 3'd3, 2'b01});
                if (exp_ar.size() == 0) begin
                    check(1'b0, "R2 unexpected descriptor read", a, '0);
                end else begin
                    e = exp_ar.pop_front();
                    check(a == e, "R5 descriptor read address", a, e);
                end
                m_arready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                m_arready = 1'b0;
                for (int b = 0; b < 6; b++) begin
                    repeat (r_gap) @(negedge clk);
                    m_rvalid = 1'b1;
                    m_rdata  = mem.exists(a + 64'(8 * b)) ? mem[a + 64'(8 * b)] : '0;
                    m_rresp  = (a + 64'(8 * b) == err_addr) ? 2'b10 : 2'b00;
                    m_rlast  = (b == 5);
                    while (!m_rready) @(negedge clk);
                    @(posedge clk);
                    @(negedge clk);
                    beats_seen++;
                    m_rvalid = 1'b0;
                    m_rlast  = 1'b0;
                    m_rresp  = 2'b00;
                end
            end
        end
    end

    // Engine model and segment monitor
    initial begin
        seg_s got, e;
        seg_ready = 1'b0; seg_done = 1'b0;
        forever begin
            @(negedge clk);
            if (seg_valid) begin
                repeat (rdy_dly) @(negedge clk);
                check(seg_valid == 1'b1, "R4 segment held until ready", 64'(seg_valid), 64'd1);
                seg_ready = 1'b1;
                got.src = seg_src; got.dst = seg_dst; got.xlen = seg_xlen; got.ylen = seg_ylen;
                got.ss = seg_src_stride; got.ds = seg_dst_stride; got.id = seg_id;
                if (exp_seg.size() == 0) begin
                    check(1'b0, "R7 unexpected segment", 64'(seg_id), '0);
                end else begin
                    e = exp_seg.pop_front();
                    check(got == e, "R3 segment fields", got[63:0] ^ got[319:256], e[63:0] ^ e[319:256]);
                    check(got.src == e.src && got.dst == e.dst, "R3 segment addresses", got.src, e.src);
                end
                @(posedge clk);
                @(negedge clk);
                seg_ready = 1'b0;
                repeat (2) @(negedge clk);
                seg_done = 1'b1;
                @(negedge clk);
                seg_done = 1'b0;
            end
        end
    end

    // Interrupt monitor
    initial begin
        logic [31:0] e;
        forever begin
            @(negedge clk);
            if (irq_pulse) begin
                if (exp_irq.size() == 0) begin
                    check(1'b0, "R6 unexpected interrupt", 64'(irq_id), '0);
                end else begin
                    e = exp_irq.pop_front();
                    check(irq_id == e, "R6 interrupt id", 64'(irq_id), 64'(e));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_desc_en = 1'b0; cfg_cyclic = 1'b0; cfg_submit = 1'b0;
        soft_rst = 1'b0; cfg_first_addr = '0;
        repeat (3) @(negedge clk);
        check({busy, m_arvalid, m_rready, seg_valid, irq_pulse, err_sticky} == 6'b0, "R11 reset state",
              64'({busy, m_arvalid, m_rready, seg_valid, irq_pulse, err_sticky}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: auto-repeat masked in descriptor mode
        cfg_cyclic = 1'b1;
        @(negedge clk);
        check(cyclic_active == 1'b1, "R9 cyclic passes when disabled", 64'(cyclic_active), 64'd1);
        cfg_desc_en = 1'b1;
        @(negedge clk);
        check(cyclic_active == 1'b0, "R9 cyclic forced off", 64'(cyclic_active), 64'd0);
        cfg_cyclic = 1'b0;

        // R2: submit ignored with descriptor mode off
        cfg_desc_en = 1'b0;
        submit(64'h4000);
        repeat (4) @(negedge clk);
        check(!busy && !m_arvalid, "R2 submit without enable", 64'({busy, m_arvalid}), '0);
        cfg_desc_en = 1'b1;

        // R3 R5 R6: three-descriptor chain with 64-bit addresses
        rdy_dly = 2;
        put_desc(64'h1000, 32'h2, 32'h11, 64'hAAAA_0000_0000_1000, 64'h5555_0000_0000_2000,
                 64'h0000_0002_0000_0040, 32'h0, 32'h3FF, 32'h0, 32'h0, 1'b1);
        put_desc(64'h0000_0002_0000_0040, 32'h0, 32'h22, 64'h0000_0001_2345_6780,
                 64'h0000_0003_8765_4320, 64'h8000, 32'h7, 32'hFF, 32'h100, 32'h200, 1'b1);
        put_desc(64'h8000, 32'h3, 32'h33, 64'hDEAD_BEEF_0000_0000, 64'hCAFE_F00D_0000_0000,
                 64'h9999_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1);
        submit(64'h1000);
        check(busy == 1'b1, "R1 busy after submit", 64'(busy), 64'd1);
        repeat (3) @(negedge clk);
        submit(64'hDEAD_0000);
        wait_idle();
        repeat (10) @(negedge clk);
        check(!m_arvalid && !busy, "R5 chain stops on last flag", 64'({m_arvalid, busy}), '0);
        check(exp_ar.size() == 0, "R5 all descriptors fetched", 64'(exp_ar.size()), '0);
        check(exp_seg.size() == 0, "R3 all segments issued", 64'(exp_seg.size()), '0);
        check(exp_irq.size() == 0, "R6 interrupts for flagged descriptors", 64'(exp_irq.size()), '0);

        // R7: error response on beat 3
        rdy_dly = 0;
        put_desc(64'h3000, 32'h3, 32'h44, 64'h1, 64'h2, 64'h0, 32'h0, 32'h7, 32'h0, 32'h0, 1'b0);
        err_addr = 64'h3018;
        submit(64'h3000);
        wait_idle();
        repeat (4) @(negedge clk);
        err_addr = '1;
        check(err_sticky == 1'b1, "R7 error flag set", 64'(err_sticky), 64'd1);
        check(!busy && !seg_valid, "R7 idle without segment", 64'({busy, seg_valid}), '0);
        put_desc(64'h6000, 32'h1, 32'h55, 64'h10, 64'h20, 64'h0, 32'h0, 32'h1F, 32'h0, 32'h0, 1'b1);
        submit(64'h6000);
        check(err_sticky == 1'b0, "R7 error cleared by submit", 64'(err_sticky), 64'd0);
        wait_idle();
        repeat (8) @(negedge clk);
        check(exp_seg.size() == 0 && exp_irq.size() == 0, "R6 no interrupt when flag clear",
              64'(exp_irq.size()), '0);

        // R8: soft reset in the middle of a slow burst
        r_gap = 3;
        beats_seen = 0;
        put_desc(64'h5000, 32'h3, 32'h66, 64'h1, 64'h2, 64'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        submit(64'h5000);
        while (beats_seen < 2) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(m_rready && busy, "R8 burst still drained", 64'({m_rready, busy}), 64'd3);
        wait_idle();
        repeat (6) @(negedge clk);
        check(beats_seen == 6, "R8 all beats consumed", 64'(beats_seen), 64'd6);
        check(!busy && !m_rready && !seg_valid, "R8 idle without segment",
              64'({busy, m_rready, seg_valid}), '0);
        r_gap = 0;

        // walker usable again after soft reset
        put_desc(64'h7000, 32'h3, 32'h77, 64'h70, 64'h80, 64'h0, 32'h0, 32'hF, 32'h0, 32'h0, 1'b1);
        submit(64'h7000);
        wait_idle();
        repeat (8) @(negedge clk);
        check(exp_seg.size() == 0 && exp_irq.size() == 0, "R5 restart after soft reset",
              64'(exp_seg.size()), '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule